// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block turns a fast auxiliary clock into a slower, evenly spaced clock-enable pulse. It is driven from a single 32-bit configuration word on a simple register bus. The word holds an enable bit and a 4-bit division value `N`. While the block is enabled, `div_tick` is high for one input cycle in every `N + 1` input cycles. `N = 0` gives a pulse on every cycle, which passes the input rate through. While the block is disabled, `div_tick` stays low. The block also refuses to take a new division value in any write that leaves it disabled.

Bus requests carry a privilege flag. Reads are open to every caller. Writes are accepted only from supervisor-mode requests. A write from user mode changes nothing and raises `rsp_err` for one cycle.

The counting engine is a three-state machine:
- **START** loads the current division value into a working copy and clears the counter.
- **RUN** counts from zero up to the working copy, fires the pulse at the top, then reloads.
- **OFF** holds the counter clear while the enable bit is low.

Its transitions are:
- START→RUN when the block is enabled; START→OFF when it is not.
- RUN→RUN on every count, including the reload at the top.
- RUN→OFF when the enable bit is cleared.
- OFF→START when the enable bit is set again.

Reset puts the engine in START. A division value written during a period is taken up only at the next reload, so a period that is under way is never cut short.

Top module: `gated_clkdiv`

## Requirements
- R1: While enabled, `div_tick` is a single-cycle pulse and consecutive pulses are exactly `N + 1` input cycles apart, where `N` is the division value held in register bits 27:24.
- R2: The enable bit is register bit 31 (1 = on). From the first cycle after a write that clears it takes effect, `div_tick` stays 0.
- R3: A supervisor write with bit 31 equal to 0 leaves the stored division value (bits 27:24) unchanged.
- R4: After reset the register reads 0x8000_0000 (enabled, `N = 0`), and `div_tick` pulses on every cycle.
- R5: A write with `req_super` = 0 leaves the register unchanged and drives `rsp_err` high for exactly the one cycle after the write edge. A supervisor write leaves `rsp_err` low.
- R6: Register bits other than 31 and 27:24 read as 0, whatever has been written to them.
- R7: A single supervisor write that sets bit 31 and carries a new division value stores both, and the following periods use the new value.
- R8: A division value written during a period does not alter that period. The period after the next pulse uses the new value.
- R9: Reads are allowed with `req_super` = 0 and return the register. A read or write at any address other than `REG_ADDR` returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Auxiliary input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| req_super | input | 1 | 1 = supervisor-mode request |
| rsp_rdata | output | DATA_W | Read data (combinational, valid while a read is presented) |
| rsp_err | output | 1 | One-cycle error after a rejected user-mode write |
| div_tick | output | 1 | Divided clock-enable pulse |

## Verification
The hardest case to reach from the ports is a division value that changes while a period is in progress. The write has to land on the edge that directly follows a pulse. The bench therefore waits until it observes a pulse and issues the write in the same cycle. It then measures the next gap, which must still show the old length, and the gap after that, which must show the new one. A second hard case is a re-enabling write that also carries a new value after a filtered write made while disabled. The bench reaches it by disabling the block, writing a value that must be dropped, and only then re-enabling with a different value.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_RUN   = 2'd1,
        ST_OFF   = 2'd2
    } div_state_e;

endpackage

// File: rtl/cdiv_bus_port.sv
module cdiv_bus_port #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int DIV_W    = 4,
    parameter int EN_BIT   = 31,
    parameter int DIV_LSB  = 24,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_super,
    input  logic              cfg_en_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    output logic              wr_ok_o,
    output logic              wr_en_o,
    output logic [DIV_W-1:0]  wr_div_o,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    logic hit;
    logic user_wr;
    logic err_q;
    logic [DATA_W-1:0] image;
    logic unused_wdata;

    assign hit      = (req_addr == REG_ADDR);
    assign wr_ok_o  = req_valid && req_write && hit && req_super;
    assign user_wr  = req_valid && req_write && hit && !req_super;
    assign wr_en_o  = req_wdata[EN_BIT];
    assign wr_div_o = req_wdata[DIV_LSB +: DIV_W];
    assign unused_wdata = ^req_wdata;

    always_comb begin
        image = '0;
        image[EN_BIT] = cfg_en_i;
        image[DIV_LSB +: DIV_W] = cfg_div_i;
    end

    assign rsp_rdata = (req_valid && !req_write && hit) ? image : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= user_wr;
        end
    end

    assign rsp_err = err_q;

    AST_USER_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        user_wr |=> ($stable(cfg_en_i) && $stable(cfg_div_i))); // R5

    AST_DIV_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok_o && !wr_en_o) |=> $stable(cfg_div_i)); // R3

    AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> ($stable(cfg_en_i) && $stable(cfg_div_i))); // R9

endmodule

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok_i,
    input  logic             wr_en_i,
    input  logic [DIV_W-1:0] wr_div_i,
    output logic             cfg_en_o,
    output logic [DIV_W-1:0] cfg_div_o
);

    logic             en_q;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b1;
            div_q <= '0;
        end else if (wr_ok_i) begin
            en_q <= wr_en_i;
            if (wr_en_i) begin
                div_q <= wr_div_i;
            end
        end
    end

    assign cfg_en_o  = en_q;
    assign cfg_div_o = div_q;

    AST_EN_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok_i && wr_en_i) |=> (cfg_div_o == $past(wr_div_i))); // R7

endmodule

// File: rtl/cdiv_engine.sv
module cdiv_engine
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int CNT_W = DIV_W;

    div_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [DIV_W-1:0] active, active_nxt;
    logic             at_top;

    assign at_top = (cnt == active);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_START;
            cnt    <= '0;
            active <= '0;
        end else begin
            state  <= state_nxt;
            cnt    <= cnt_nxt;
            active <= active_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt  = state;
        cnt_nxt    = cnt;
        active_nxt = active;
        unique case (state)
            ST_START: begin
                cnt_nxt    = '0;
                active_nxt = div_i;
                state_nxt  = en_i ? ST_RUN : ST_OFF;
            end
            ST_RUN: begin
                if (!en_i) begin
                    state_nxt = ST_OFF;
                    cnt_nxt   = '0;
                end else if (at_top) begin
                    cnt_nxt    = '0;
                    active_nxt = div_i;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_OFF: begin
                cnt_nxt = '0;
                if (en_i) begin
                    state_nxt = ST_START;
                end
            end
            default: begin
                state_nxt = ST_START;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        tick_o = 1'b0;
        unique case (state)
            ST_RUN:   tick_o = en_i && at_top;
            ST_START: tick_o = 1'b0;
            ST_OFF:   tick_o = 1'b0;
            default:  tick_o = 1'b0;
        endcase
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt <= active)); // R1

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o); // R2

    AST_RELOAD_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt == '0)); // R1

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !at_top) |=> $stable(active)); // R8

endmodule

// File: rtl/gated_clkdiv.sv
module gated_clkdiv #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int DIV_W   = 4,
    parameter int EN_BIT  = 31,
    parameter int DIV_LSB = 24,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_super,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              div_tick
);

    logic             wr_ok;
    logic             wr_en;
    logic [DIV_W-1:0] wr_div;
    logic             cfg_en;
    logic [DIV_W-1:0] cfg_div;

    cdiv_bus_port #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .DIV_W   (DIV_W),
        .EN_BIT  (EN_BIT),
        .DIV_LSB (DIV_LSB),
        .REG_ADDR(REG_ADDR)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_super(req_super),
        .cfg_en_i (cfg_en),
        .cfg_div_i(cfg_div),
        .wr_ok_o  (wr_ok),
        .wr_en_o  (wr_en),
        .wr_div_o (wr_div),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err)
    );

    cdiv_cfg_reg #(
        .DIV_W(DIV_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok_i  (wr_ok),
        .wr_en_i  (wr_en),
        .wr_div_i (wr_div),
        .cfg_en_o (cfg_en),
        .cfg_div_o(cfg_div)
    );

    cdiv_engine #(
        .DIV_W(DIV_W)
    ) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (cfg_en),
        .div_i (cfg_div),
        .tick_o(div_tick)
    );

endmodule

// File: tb/sim_gated_clkdiv.sv
module sim_gated_clkdiv;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int VDIV [0:NVEC-1] = '{0, 1, 2, 3, 5, 7, 10, 15};
    localparam int VGAP [0:NVEC-1] = '{1, 2, 3, 4, 6, 8, 11, 16};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_super = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        div_tick;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int nticks = 0;
    int last_t = 0;
    int prev_t = 0;

    gated_clkdiv u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_super(req_super),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err),
        .div_tick (div_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && div_tick) begin
            prev_t = last_t;
            last_t = cyc;
            nticks = nticks + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] data, input logic sup, input logic [3:0] addr);
        req_valid = 1'b1; req_write = 1'b1; req_wdata = data;
        req_super = sup; req_addr = addr;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; req_super = 1'b0;
    endtask

    task automatic rd(input logic sup, input logic [3:0] addr, output logic [31:0] data);
        req_valid = 1'b1; req_write = 1'b0; req_super = sup; req_addr = addr;
        #1;
        data = rsp_rdata;
        req_valid = 1'b0; req_super = 1'b0; req_addr = '0;
    endtask

    task automatic wait_ticks(input int n);
        int target;
        target = nticks + n;
        while (nticks < target) begin
            @(negedge clk); #1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n0;

        // Reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R4 tick low in reset", {31'b0, div_tick}, 32'h0);
        rst_n = 1'b1;
        rd(1'b0, 4'h0, r);
        check("R4 reset value", r, 32'h8000_0000);
        wait_ticks(3);
        check("R4 pulse every cycle", last_t - prev_t, 1);

        // Vector table: division values and expected pulse spacing
        for (int i = 0; i < NVEC; i++) begin
            wr(32'h8000_0000 | (VDIV[i] << 24), 1'b1, 4'h0);
            wait_ticks(3);
            check($sformatf("R1 gap div=%0d", VDIV[i]), last_t - prev_t, VGAP[i]);
        end

        // R6: unused bits read zero
        wr(32'hFFFF_FFFF, 1'b1, 4'h0);
        rd(1'b1, 4'h0, r);
        check("R6 unused bits", r, 32'h8F00_0000);

        // R8: mid-period change, written right after a pulse
        wr(32'h8600_0000, 1'b1, 4'h0);
        wait_ticks(2);
        wr(32'h8200_0000, 1'b1, 4'h0);
        wait_ticks(1);
        check("R8 old period kept", last_t - prev_t, 7);
        wait_ticks(1);
        check("R8 new period used", last_t - prev_t, 3);

        // R5: user-mode write rejected with one-cycle error
        wr(32'h8900_0000, 1'b0, 4'h0);
        check("R5 err raised", {31'b0, rsp_err}, 32'h1);
        @(posedge clk); #1;
        check("R5 err one cycle", {31'b0, rsp_err}, 32'h0);
        rd(1'b0, 4'h0, r);
        check("R9 user read / R5 unchanged", r, 32'h8200_0000);
        wr(32'h8200_0000, 1'b1, 4'h0);
        check("R5 no err on supervisor write", {31'b0, rsp_err}, 32'h0);

        // R9: foreign address
        wr(32'h8700_0000, 1'b1, 4'h3);
        rd(1'b1, 4'h3, r);
        check("R9 foreign read zero", r, 32'h0);
        rd(1'b1, 4'h0, r);
        check("R9 foreign write ignored", r, 32'h8200_0000);

        // R2: disable stops pulses
        wr(32'h0500_0000, 1'b1, 4'h0);
        rd(1'b1, 4'h0, r);
        check("R2 disabled readback", r, 32'h0200_0000);
        n0 = nticks;
        repeat (20) @(posedge clk);
        #1;
        check("R2 no pulses while off", nticks, n0);

        // R3: division write dropped while disabled
        wr(32'h0900_0000, 1'b1, 4'h0);
        rd(1'b1, 4'h0, r);
        check("R3 div held while off", r, 32'h0200_0000);
        repeat (5) @(posedge clk);
        #1;
        check("R2 still quiet", nticks, n0);

        // R7: enable and new value in one write
        wr(32'h8300_0000, 1'b1, 4'h0);
        rd(1'b1, 4'h0, r);
        check("R7 enable with value", r, 32'h8300_0000);
        wait_ticks(2);
        check("R7 new period after enable", last_t - prev_t, 4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule